// File: doc/BRIEF.md
# Burst Column Sequencer

This block generates the column address of every beat in one memory burst, the same way a synchronous DRAM steps through columns internally after a read or write command. A one-cycle `start` pulse captures the start column, the burst length code and the ordering mode. From the next clock onward the block presents one column per cycle, together with a valid flag and a flag that marks the final beat.

Two orderings are supported. In sequential ordering the low bits count upward and wrap inside an aligned block the size of the burst. In interleaved ordering the low bits are the start bits XORed with the beat index. A new `start` can arrive on any cycle, including in the middle of a burst, and it restarts the sequence. A `stop` pulse ends the burst at once. The block can be used as a reference model for beat tracking in a memory controller, or as the column stepper inside a device-side memory model.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `col_valid` and `col_last` are 0.
- R2: When `start` is sampled high at an edge, that same edge presents beat 0: `col_valid` = 1 and `col` = `start_col`. This holds in both orderings.
- R3: The burst length code maps as follows: `bl_code` 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. With `interleave` = 0, beat i takes the start column and replaces its low log2(BL) bits with (start low bits + i) mod BL.
- R4: With `interleave` = 1, beat i takes the start column and XORs its low log2(BL) bits with i.
- R5: Column bits above the low log2(BL) bits equal those of `start_col` for every beat of the burst.
- R6: `col_last` is 1 only on beat BL-1, and only while `col_valid` is 1. On the edge after the last beat, `col_valid` falls unless a new `start` is sampled. With BL = 1 a single beat is produced, and `col_last` is 1 on it.
- R7: When `stop` is sampled high without `start`, `col_valid` and `col_last` are 0 after that edge. When `start` and `stop` are high together, `start` takes priority.
- R8: A `start` sampled during a burst abandons the old burst. The next edge shows beat 0 of the new burst.
- R9: The burst length and ordering are captured when `start` is sampled. Changes on `bl_code` or `interleave` during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst at `start_col` |
| stop | input | 1 | Terminate the current burst |
| start_col | input | COL_W | Start column of the burst |
| bl_code | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| interleave | input | 1 | 0 sequential ordering, 1 interleaved ordering |
| col | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | The current beat is the final one |

## Verification
The hardest condition to reach is a burst that has its configuration inputs changed, or that is cut short by a new `start`, while beats are still in flight. The bench reaches it by driving fresh `bl_code`, `interleave` and `start` values on negative edges in the middle of a burst. It then checks every following beat against the captured settings, and separately against the new burst. A table also covers starting columns that sit at the top of the wrap block and in the upper address range, so that wrap and XOR carries that could leak into the upper bits are exercised.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MAX_BL_LOG = 3;
  localparam int BL_CODE_W  = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // low-bit mask of the wrap block for a burst length code
  function automatic logic [MAX_BL_LOG-1:0] beat_mask(input logic [BL_CODE_W-1:0] code);
    logic [MAX_BL_LOG:0] t;
    t = (MAX_BL_LOG+1)'(1) << code;
    return MAX_BL_LOG'(t - (MAX_BL_LOG+1)'(1));
  endfunction
endpackage

// File: rtl/bcs_beat_ctl.sv
module bcs_beat_ctl
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    stop,
  input  logic [COL_W-1:0]        start_col,
  input  logic [BL_CODE_W-1:0]    bl_code,
  input  logic                    interleave,
  output logic                    active,
  output logic [MAX_BL_LOG-1:0]   beat,
  output logic [COL_W-1:0]        base,
  output logic [BL_CODE_W-1:0]    code_q,
  output order_e                  ord_q,
  output logic                    last
);
  assign last = active && (beat == beat_mask(code_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat   <= '0;
      base   <= '0;
      code_q <= '0;
      ord_q  <= ORD_SEQ;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
      base   <= start_col;
      code_q <= bl_code;
      ord_q  <= order_e'(interleave);
    end else if (stop) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + MAX_BL_LOG'(1);
      end
    end
  end

  // R2: a sampled start opens beat 0
  a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && beat == '0));
  // R7: stop alone closes the burst
  a_r7_stop_closes: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !active);
  // R9: captured settings hold while no start arrives
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
    (active && !start) |=> ($stable(code_q) && $stable(ord_q)));
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]      base,
  input  logic [MAX_BL_LOG-1:0] beat,
  input  logic [BL_CODE_W-1:0]  code,
  input  order_e                ord,
  output logic [COL_W-1:0]      col
);
  localparam int HI_W = COL_W - MAX_BL_LOG;

  logic [MAX_BL_LOG-1:0] mask;
  logic [MAX_BL_LOG-1:0] low_seq;
  logic [MAX_BL_LOG-1:0] low_ilv;
  logic [MAX_BL_LOG-1:0] low_sel;

  always_comb begin
    mask    = beat_mask(code);
    low_seq = base[MAX_BL_LOG-1:0] + beat;
    low_ilv = base[MAX_BL_LOG-1:0] ^ beat;
    low_sel = (ord == ORD_ILV) ? low_ilv : low_seq;
  end

  for (genvar b = 0; b < MAX_BL_LOG; b++) begin : g_low
    assign col[b] = mask[b] ? low_sel[b] : base[b];
  end

  if (HI_W > 0) begin : g_hi
    assign col[COL_W-1:MAX_BL_LOG] = base[COL_W-1:MAX_BL_LOG];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  input  logic             interleave,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);
  logic                  active;
  logic [MAX_BL_LOG-1:0] beat;
  logic [COL_W-1:0]      base;
  logic [BL_CODE_W-1:0]  code_q;
  order_e                ord_q;
  logic                  last;
  logic [COL_W-1:0]      hi_mask;

  bcs_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .start_col(start_col), .bl_code(bl_code), .interleave(interleave),
    .active(active), .beat(beat), .base(base), .code_q(code_q),
    .ord_q(ord_q), .last(last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base(base), .beat(beat), .code(code_q), .ord(ord_q), .col(col)
  );

  assign col_valid = active;
  assign col_last  = last;
  assign hi_mask   = ~{{(COL_W-MAX_BL_LOG){1'b0}}, beat_mask(code_q)};

  // R6: last only on a valid beat
  a_r6_last_valid: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);
  // R6: burst ends after last beat
  a_r6_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (col_last && !start) |=> !col_valid);
  // R6: single-beat burst
  a_r6_bl1_single: assert property (@(posedge clk) disable iff (rst)
    (start && bl_code == 2'd0) |=> col_last);
  // R2: beat 0 is the start column
  a_r2_first_col: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_valid && col == $past(start_col)));
  // R5: upper column bits fixed within a burst
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !start && !stop) |=>
      ((col & hi_mask) == ($past(col) & hi_mask)));
  // R1: nothing valid right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!col_valid && !col_last));
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [9:0] start_col = '0;
  logic [1:0] bl_code = '0;
  logic       interleave = 1'b0;
  logic [9:0] col;
  logic       col_valid;
  logic       col_last;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(10)) u_burst_col_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .col(col),
    .col_valid(col_valid), .col_last(col_last)
  );

  // {bl_code, interleave, start_col}
  localparam logic [12:0] VEC [0:7] = '{
    {2'd3, 1'b0, 10'h125},
    {2'd3, 1'b1, 10'h0FB},
    {2'd2, 1'b0, 10'h3FE},
    {2'd2, 1'b1, 10'h201},
    {2'd1, 1'b0, 10'h011},
    {2'd1, 1'b1, 10'h2A1},
    {2'd0, 1'b0, 10'h1FF},
    {2'd3, 1'b1, 10'h3FF}
  };

  function automatic int exp_col(input int code, input int ilv, input int s, input int i);
    int bl;
    int lo;
    bl = 1 << code;
    lo = s % bl;
    if (ilv != 0) return (s - lo) + (lo ^ i);
    return (s - lo) + ((lo + i) % bl);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input int code, input int ilv, input int s);
    @(negedge clk);
    start      = 1'b1;
    bl_code    = 2'(code);
    interleave = ilv[0];
    start_col  = 10'(s);
    @(negedge clk);
    start = 1'b0;
  endtask

  // called right after launch: checks every beat then the idle cycle
  task automatic follow(input int code, input int ilv, input int s, input int from_beat);
    int bl;
    bl = 1 << code;
    for (int i = from_beat; i < bl; i++) begin
      if (i > from_beat) @(negedge clk);
      chk("R3/R4/R5 col", int'(col), exp_col(code, ilv, s, i));
      chk("R2 valid", int'(col_valid), 1);
      chk("R6 last", int'(col_last), (i == bl - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R6 valid drops after last", int'(col_valid), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(col_valid), 0);
    chk("R1 reset last", int'(col_last), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < 8; v++) begin
      launch(int'(VEC[v][12:11]), int'(VEC[v][10]), int'(VEC[v][9:0]));
      follow(int'(VEC[v][12:11]), int'(VEC[v][10]), int'(VEC[v][9:0]), 0);
    end

    // R7: stop ends burst
    launch(3, 0, 10'h040);
    @(negedge clk);
    chk("R7 beat1 before stop", int'(col), 'h041);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R7 stop valid", int'(col_valid), 0);
    chk("R7 stop last", int'(col_last), 0);
    @(negedge clk);
    chk("R7 stays idle", int'(col_valid), 0);

    // R7: start wins over stop
    @(negedge clk);
    start = 1'b1; stop = 1'b1; bl_code = 2'd2; interleave = 1'b0; start_col = 10'h0C6;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R7 start priority valid", int'(col_valid), 1);
    chk("R7 start priority col", int'(col), 'h0C6);
    @(negedge clk);
    chk("R7 start priority beat1", int'(col), 'h0C7);
    @(negedge clk);
    @(negedge clk);
    chk("R7 start priority last", int'(col_last), 1);
    @(negedge clk);

    // R8: restart mid-burst
    launch(2, 0, 10'h100);
    @(negedge clk);
    chk("R8 old beat1", int'(col), 'h101);
    start = 1'b1; bl_code = 2'd1; interleave = 1'b1; start_col = 10'h055;
    @(negedge clk);
    start = 1'b0;
    follow(1, 1, 'h055, 0);

    // R9: config change mid-burst ignored
    launch(3, 0, 10'h003);
    chk("R9 beat0", int'(col), 'h003);
    bl_code = 2'd0; interleave = 1'b1; start_col = 10'h3C0;
    @(negedge clk);
    follow(3, 0, 'h003, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule